// File: doc/BRIEF.md
# Wake-Source Power Enable Controller

This block sits in the always-on domain and drives two board power-enable lines, a main enable and an auxiliary enable, from a set of wake-up events. The events are four digital wake pads, a one-cycle alarm pulse, and software set and clear strobes. Each pad is brought into the local clock domain through a flop chain. A per-pad polarity turns it into an "active" level, and a wake event is that level going from inactive to active.

Two 3-bit select fields decide which events may raise each enable. The main enable listens to the pads, the alarm and software. The auxiliary enable listens to the main enable, the alarm and software. An optional record mode remembers a pad 0 or pad 1 wake edge that arrives while the main enable is already high. Power then comes back one cycle after the next software power-down.

The block keeps a one-hot record of the event that last turned the board on. It also keeps a registered view of the current event levels.

Top module: `wake_pwr_ctrl`

## Requirements
- R1: Synchronous active-high reset drives both enables low and clears the wake record and the live event view to zero.
- R2: A pad level change applied before rising edge k reaches the enables, the wake record and the live view after rising edge k+2. The path is two synchronizer flops plus the output register. Alarm and software strobes act after the first rising edge.
- R3: Pads 0 and 1 wake on a rising level. Pad 2 takes a 2-bit compare mode: 0, 1 and 3 wake on a rising level, and 2 wakes on a falling level. Pad 3 wakes on a falling level when `pull_up_i` is 1 and on a rising level otherwise.
- R4: `main_sel_i` bit 0 lets any pad event set the main enable, bit 1 the alarm, and bit 2 `sw_on_i`. An event whose bit is 0 does not change the main enable.
- R5: `aux_sel_i` bit 0 makes the auxiliary enable rise in the same cycle the main enable rises and fall when the main enable falls. Bit 1 lets the alarm set it and bit 2 lets `sw_on_i` set it. With value 2 only the alarm can raise it.
- R6: `sw_off_i` clears the main enable only when `main_sel_i` bit 2 is 1, and clears the auxiliary enable only when `aux_sel_i` bit 2 is 1. A clear beats a set in the same cycle.
- R7: An enable that is high stays high until it is cleared; further events leave it and the wake record unchanged. A pad held active through a power-down must go inactive and active again before it can wake the board.
- R8: With `rec_en_i` high and `main_sel_i` bit 0 set, a pad 0 or pad 1 event seen while the main enable is high is remembered. After the main enable is cleared it stays low for exactly one cycle and then rises again, and the memory is emptied.
- R9: `wake_src_o` is one-hot: bits 0 to 3 are pads 0 to 3, bit 4 the alarm, bit 5 software. It is loaded only when both enables are low and at least one rises. It takes the lowest-index enabled cause: pads count under `main_sel_i` bit 0, and alarm or software count when their bit is set in either select. A replayed power-on records the remembered pad. The record holds at all other times.
- R10: `live_evt_o` bits 0 to 3 show each synchronized pad's active level after polarity, bit 4 the alarm input and bit 5 `sw_on_i`, all registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 4 | Raw wake pad levels |
| alarm_i | input | 1 | Alarm event pulse |
| sw_on_i | input | 1 | Software power-on strobe |
| sw_off_i | input | 1 | Software power-off strobe |
| cmp_mode_i | input | 2 | Pad 2 compare mode |
| pull_up_i | input | 1 | Pad 3 pull-up mode (falling-edge wake) |
| main_sel_i | input | 3 | Main enable source select |
| aux_sel_i | input | 3 | Auxiliary enable source select |
| rec_en_i | input | 1 | Enable wake-edge record and replay |
| pwr_main_o | output | 1 | Main power enable |
| pwr_aux_o | output | 1 | Auxiliary power enable |
| wake_src_o | output | 6 | One-hot cause of last power-on |
| live_evt_o | output | 6 | Registered live event levels |

## Verification
Directed sequences cover each pad's wake polarity, including the compare and pull-up modes. They apply each select bit in isolation, which separates a source that is only masked from one that is wired wrongly. They also cover a clear and a set in the same cycle, a pad held high across a power-down, and a record-and-replay cycle whose one-cycle dip proves the ordering of clear and replay. A seeded random phase then toggles pads and strobes sparsely under select and mode settings that change every few hundred cycles, with overlaps of alarm, software and pad events. This exposes errors in priority and in the choice of wake record that single events cannot reveal.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // Source indices in the wake record: pads occupy the low bits.
  localparam int unsigned PAD_CNT   = 4;
  localparam int unsigned SRC_ALARM = PAD_CNT;
  localparam int unsigned SRC_SW    = PAD_CNT + 1;
  localparam int unsigned SRC_CNT   = PAD_CNT + 2;

  // Compare pad modes; only the below-threshold mode is active low.
  typedef enum logic [1:0] {
    CMP_WIN_A = 2'd0,
    CMP_WIN_B = 2'd1,
    CMP_BELOW = 2'd2,
    CMP_ABOVE = 2'd3
  } cmp_mode_e;

  // Select field layout shared by both enables.
  typedef struct packed {
    logic sw;     // bit2: software strobes
    logic alarm;  // bit1: alarm pulse
    logic base;   // bit0: pads (main) or main enable (aux)
  } src_sel_t;
endpackage

// File: rtl/wake_pad_sync.sv
module wake_pad_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);
  localparam int unsigned LAST = STAGES - 1;

  // chain[0..LAST] synchronizes; chain[STAGES] keeps the prior level.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[LAST];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/wake_edge_sel.sv
module wake_edge_sel #(
  parameter int unsigned NUM_PADS = 4
) (
  input  logic [NUM_PADS-1:0] lvl,
  input  logic [NUM_PADS-1:0] lvl_prev,
  input  logic [NUM_PADS-1:0] act_low,
  output logic [NUM_PADS-1:0] act,
  output logic [NUM_PADS-1:0] evt
);
  logic [NUM_PADS-1:0] act_prev;

  // Polarity is applied to both samples so a mode change alone
  // never looks like a transition of the raw pad.
  always_comb begin
    act      = lvl ^ act_low;
    act_prev = lvl_prev ^ act_low;
    evt      = act & ~act_prev;
  end
endmodule

// File: rtl/pwr_enable_core.sv
module pwr_enable_core
  import wake_pkg::*;
#(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned REC_PADS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_evt,
  input  logic                alarm,
  input  logic                sw_on,
  input  logic                sw_off,
  input  src_sel_t            sel_main,
  input  src_sel_t            sel_aux,
  input  logic                rec_en,
  output logic                main_q,
  output logic                aux_q,
  output logic                main_nxt,
  output logic                aux_nxt,
  output logic                replay,
  output logic [REC_PADS-1:0] pend_q
);
  logic pad_hit, set_main, clr_main, set_aux, clr_aux;

  always_comb begin
    replay   = !main_q && (|pend_q);
    pad_hit  = sel_main.base && (|pad_evt);
    set_main = !main_q && (pad_hit || (sel_main.alarm && alarm) ||
                           (sel_main.sw && sw_on) || replay);
    clr_main = sel_main.sw && sw_off;
    main_nxt = !clr_main && (main_q || set_main);
    set_aux  = !aux_q && ((sel_aux.base && main_nxt && !main_q) ||
                          (sel_aux.alarm && alarm) || (sel_aux.sw && sw_on));
    clr_aux  = (sel_aux.sw && sw_off) || (sel_aux.base && main_q && !main_nxt);
    aux_nxt  = !clr_aux && (aux_q || set_aux);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      main_q <= main_nxt;
      aux_q  <= aux_nxt;
    end
  end

  // Pending wake memory for the low pads: filled while powered, drained
  // on the replay cycle that follows a power-down.
  always_ff @(posedge clk) begin
    if (rst)                               pend_q <= '0;
    else if (replay)                       pend_q <= '0;
    else if (rec_en && main_q && sel_main.base)
      pend_q <= pend_q | pad_evt[REC_PADS-1:0];
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (sel_main.sw && sw_off) |=> !main_q); // R6

  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (main_q && !(sel_main.sw && sw_off)) |=> main_q); // R7

  AST_REPLAY_RISE: assert property (@(posedge clk) disable iff (rst)
    (!main_q && (|pend_q) && !(sel_main.sw && sw_off)) |=> main_q); // R8

  AST_AUX_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!aux_q && sel_aux == 3'b000) |=> !aux_q); // R5
endmodule

// File: rtl/wake_src_log.sv
module wake_src_log #(
  parameter int unsigned SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             main_q,
  input  logic             aux_q,
  input  logic             main_nxt,
  input  logic             aux_nxt,
  input  logic [SRC_W-1:0] cause,
  input  logic [SRC_W-1:0] live_in,
  output logic [SRC_W-1:0] src_q,
  output logic [SRC_W-1:0] live_q
);
  logic             power_on;
  logic [SRC_W-1:0] first_cause;

  always_comb begin
    power_on    = !main_q && !aux_q && (main_nxt || aux_nxt);
    first_cause = cause & (~cause + {{(SRC_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      live_q <= '0;
    end else begin
      live_q <= live_in;
      if (power_on) src_q <= first_cause;
    end
  end

  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_q)); // R9

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (main_q || aux_q) |=> $stable(src_q)); // R9
endmodule

// File: rtl/wake_pwr_ctrl.sv
module wake_pwr_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned NUM_PADS    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CMP_PAD     = 2,
  parameter int unsigned PULL_PAD    = 3,
  parameter int unsigned REC_PADS    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PADS-1:0]   pad_i,
  input  logic                  alarm_i,
  input  logic                  sw_on_i,
  input  logic                  sw_off_i,
  input  logic [1:0]            cmp_mode_i,
  input  logic                  pull_up_i,
  input  logic [2:0]            main_sel_i,
  input  logic [2:0]            aux_sel_i,
  input  logic                  rec_en_i,
  output logic                  pwr_main_o,
  output logic                  pwr_aux_o,
  output logic [NUM_PADS+1:0]   wake_src_o,
  output logic [NUM_PADS+1:0]   live_evt_o
);
  localparam int unsigned SRC_W   = NUM_PADS + 2;
  localparam int unsigned IDX_ALM = NUM_PADS;
  localparam int unsigned IDX_SW  = NUM_PADS + 1;
  localparam int unsigned GAP_W   = NUM_PADS - REC_PADS;

  src_sel_t sel_main, sel_aux;
  assign sel_main = src_sel_t'(main_sel_i);
  assign sel_aux  = src_sel_t'(aux_sel_i);

  logic [NUM_PADS-1:0] lvl, lvl_prev, act_low, act, evt;

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    wake_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d      (pad_i[i]),
      .q      (lvl[i]),
      .q_prev (lvl_prev[i])
    );
    if (i == CMP_PAD) begin : g_cmp
      assign act_low[i] = (cmp_mode_i == CMP_BELOW);
    end else if (i == PULL_PAD) begin : g_pull
      assign act_low[i] = pull_up_i;
    end else begin : g_plain
      assign act_low[i] = 1'b0;
    end
  end

  wake_edge_sel #(.NUM_PADS(NUM_PADS)) u_edge (
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .act_low  (act_low),
    .act      (act),
    .evt      (evt)
  );

  logic                main_q, aux_q, main_nxt, aux_nxt, replay;
  logic [REC_PADS-1:0] pend_q;

  pwr_enable_core #(.NUM_PADS(NUM_PADS), .REC_PADS(REC_PADS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .pad_evt  (evt),
    .alarm    (alarm_i),
    .sw_on    (sw_on_i),
    .sw_off   (sw_off_i),
    .sel_main (sel_main),
    .sel_aux  (sel_aux),
    .rec_en   (rec_en_i),
    .main_q   (main_q),
    .aux_q    (aux_q),
    .main_nxt (main_nxt),
    .aux_nxt  (aux_nxt),
    .replay   (replay),
    .pend_q   (pend_q)
  );

  logic [SRC_W-1:0]    cause, live_in;
  logic [NUM_PADS-1:0] pad_cause;

  always_comb begin
    pad_cause = (evt & {NUM_PADS{sel_main.base}}) |
                {{GAP_W{1'b0}}, pend_q & {REC_PADS{replay}}};
    cause = '0;
    cause[NUM_PADS-1:0] = pad_cause;
    cause[IDX_ALM]      = alarm_i && (sel_main.alarm || sel_aux.alarm);
    cause[IDX_SW]       = sw_on_i && (sel_main.sw || sel_aux.sw);
    live_in = '0;
    live_in[NUM_PADS-1:0] = act;
    live_in[IDX_ALM]      = alarm_i;
    live_in[IDX_SW]       = sw_on_i;
  end

  wake_src_log #(.SRC_W(SRC_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .main_q   (main_q),
    .aux_q    (aux_q),
    .main_nxt (main_nxt),
    .aux_nxt  (aux_nxt),
    .cause    (cause),
    .live_in  (live_in),
    .src_q    (wake_src_o),
    .live_q   (live_evt_o)
  );

  assign pwr_main_o = main_q;
  assign pwr_aux_o  = aux_q;
endmodule

// File: tb/wake_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module wake_pwr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pad_i = '0;
  logic       alarm_i = 1'b0, sw_on_i = 1'b0, sw_off_i = 1'b0;
  logic [1:0] cmp_mode_i = 2'd0;
  logic       pull_up_i = 1'b0;
  logic [2:0] main_sel_i = 3'b001, aux_sel_i = 3'b001;
  logic       rec_en_i = 1'b0;
  logic       pwr_main_o, pwr_aux_o;
  logic [5:0] wake_src_o, live_evt_o;

  int unsigned n_vec = 0, n_bad = 0;
  logic        rand_on = 1'b0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  wake_pwr_ctrl u_wake_pwr_ctrl (
    .clk(clk), .rst(rst), .pad_i(pad_i), .alarm_i(alarm_i),
    .sw_on_i(sw_on_i), .sw_off_i(sw_off_i), .cmp_mode_i(cmp_mode_i),
    .pull_up_i(pull_up_i), .main_sel_i(main_sel_i), .aux_sel_i(aux_sel_i),
    .rec_en_i(rec_en_i), .pwr_main_o(pwr_main_o), .pwr_aux_o(pwr_aux_o),
    .wake_src_o(wake_src_o), .live_evt_o(live_evt_o)
  );

  // Active level per pad from the polarity rules (R3).
  function automatic logic [3:0] act_of(logic [3:0] raw, logic [1:0] cm, logic pu);
    logic [3:0] inv;
    inv = {pu, (cm == 2'd2), 2'b00};
    return raw ^ inv;
  endfunction

  function automatic logic [5:0] first_of(logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 6'(1) << i;
    return 6'd0;
  endfunction

  // Reference model built from the requirements.
  logic [3:0] m_s1, m_s2, m_s3;
  logic       m_main, m_aux;
  logic [1:0] m_pend;
  logic [5:0] m_src, m_live;

  always @(posedge clk) begin
    logic [3:0] ev;
    logic       rep, sm, nm, sa, na, cm, ca;
    logic [5:0] cz;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_main <= 0; m_aux <= 0; m_pend <= '0; m_src <= '0; m_live <= '0;
    end else begin
      ev  = act_of(m_s2, cmp_mode_i, pull_up_i) & ~act_of(m_s3, cmp_mode_i, pull_up_i);
      rep = !m_main && (m_pend != 0);
      sm  = !m_main && ((main_sel_i[0] && ev != 0) || (main_sel_i[1] && alarm_i) ||
                        (main_sel_i[2] && sw_on_i) || rep);
      cm  = main_sel_i[2] && sw_off_i;
      nm  = !cm && (m_main || sm);
      sa  = !m_aux && ((aux_sel_i[0] && nm && !m_main) || (aux_sel_i[1] && alarm_i) ||
                       (aux_sel_i[2] && sw_on_i));
      ca  = (aux_sel_i[2] && sw_off_i) || (aux_sel_i[0] && m_main && !nm);
      na  = !ca && (m_aux || sa);
      cz  = {sw_on_i && (main_sel_i[2] || aux_sel_i[2]),
             alarm_i && (main_sel_i[1] || aux_sel_i[1]),
             (ev & {4{main_sel_i[0]}}) | {2'b00, rep ? m_pend : 2'b00}};
      if (!m_main && !m_aux && (nm || na)) m_src <= first_of(cz);
      if (rep) m_pend <= '0;
      else if (rec_en_i && m_main && main_sel_i[0]) m_pend <= m_pend | ev[1:0];
      m_main <= nm; m_aux <= na;
      m_live <= {sw_on_i, alarm_i, act_of(m_s2, cmp_mode_i, pull_up_i)};
      m_s3 <= m_s2; m_s2 <= m_s1; m_s1 <= pad_i;
    end
  end

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_off();
    sw_off_i = 1'b1; tick(1); sw_off_i = 1'b0;
  endtask

  task automatic pulse_on();
    sw_on_i = 1'b1; tick(1); sw_on_i = 1'b0;
  endtask

  task automatic pulse_alarm();
    alarm_i = 1'b1; tick(1); alarm_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3); rst = 1'b0; tick(1);
    chk("R1 main", {5'd0, pwr_main_o}, 6'd0);
    chk("R1 aux", {5'd0, pwr_aux_o}, 6'd0);
    chk("R1 src", wake_src_o, 6'd0);
    chk("R1 live", live_evt_o, 6'd0);

    pad_i[1] = 1'b1; tick(2);
    chk("R2 main early", {5'd0, pwr_main_o}, 6'd0);
    tick(1);
    chk("R2 main", {5'd0, pwr_main_o}, 6'd1);
    chk("R5 aux follows", {5'd0, pwr_aux_o}, 6'd1);
    chk("R9 src pad1", wake_src_o, 6'b000010);
    chk("R10 live pad1", live_evt_o, 6'b000010);

    pad_i[0] = 1'b1; tick(4);
    chk("R7 main held", {5'd0, pwr_main_o}, 6'd1);
    chk("R7 src held", wake_src_o, 6'b000010);

    pulse_off();
    chk("R6 masked clear", {5'd0, pwr_main_o}, 6'd1);
    main_sel_i = 3'b101; aux_sel_i = 3'b101;
    pulse_off();
    chk("R6 main cleared", {5'd0, pwr_main_o}, 6'd0);
    chk("R6 aux cleared", {5'd0, pwr_aux_o}, 6'd0);
    tick(5);
    chk("R7 no retrigger", {5'd0, pwr_main_o}, 6'd0);
    pad_i[0] = 1'b0; tick(3); pad_i[0] = 1'b1; tick(3);
    chk("R7 rearmed", {5'd0, pwr_main_o}, 6'd1);
    chk("R9 src pad0", wake_src_o, 6'b000001);

    pad_i = '0; pulse_off(); tick(4);
    sw_on_i = 1'b1; sw_off_i = 1'b1; tick(1); sw_on_i = 1'b0; sw_off_i = 1'b0;
    chk("R6 clear beats set", {5'd0, pwr_main_o}, 6'd0);

    pull_up_i = 1'b1; pad_i[3] = 1'b1; tick(4);
    chk("R3 pull-up rise ignored", {5'd0, pwr_main_o}, 6'd0);
    pad_i[3] = 1'b0; tick(3);
    chk("R3 pull-up fall wakes", {5'd0, pwr_main_o}, 6'd1);
    chk("R3 src pad3", wake_src_o, 6'b001000);
    pulse_off(); pull_up_i = 1'b0; tick(4);

    cmp_mode_i = 2'd2; pad_i[2] = 1'b1; tick(4);
    chk("R3 cmp-below rise ignored", {5'd0, pwr_main_o}, 6'd0);
    pad_i[2] = 1'b0; tick(3);
    chk("R3 cmp-below fall wakes", {5'd0, pwr_main_o}, 6'd1);
    chk("R3 src pad2", wake_src_o, 6'b000100);
    pulse_off(); cmp_mode_i = 2'd3; tick(4);
    pad_i[2] = 1'b1; tick(3);
    chk("R3 cmp-above rise wakes", {5'd0, pwr_main_o}, 6'd1);
    pulse_off(); pad_i[2] = 1'b0; cmp_mode_i = 2'd0; tick(4);

    pulse_alarm(); tick(2);
    chk("R4 alarm masked main", {5'd0, pwr_main_o}, 6'd0);
    chk("R4 alarm masked aux", {5'd0, pwr_aux_o}, 6'd0);
    main_sel_i = 3'b010; aux_sel_i = 3'b000;
    pulse_alarm();
    chk("R4 alarm main", {5'd0, pwr_main_o}, 6'd1);
    chk("R4 aux untouched", {5'd0, pwr_aux_o}, 6'd0);
    chk("R9 src alarm", wake_src_o, 6'b010000);
    main_sel_i = 3'b100; pulse_off(); tick(2);

    main_sel_i = 3'b000; aux_sel_i = 3'b010;
    pulse_alarm();
    chk("R5 aux alarm only", {5'd0, pwr_aux_o}, 6'd1);
    chk("R5 main stays low", {5'd0, pwr_main_o}, 6'd0);
    aux_sel_i = 3'b110; pulse_off();
    chk("R6 aux clear", {5'd0, pwr_aux_o}, 6'd0);

    main_sel_i = 3'b100; aux_sel_i = 3'b000;
    pulse_on();
    chk("R4 sw main", {5'd0, pwr_main_o}, 6'd1);
    chk("R9 src sw", wake_src_o, 6'b100000);
    pulse_off(); tick(2);

    main_sel_i = 3'b101; rec_en_i = 1'b1;
    pulse_on();
    pad_i[1] = 1'b1; tick(4); pad_i[1] = 1'b0; tick(4);
    chk("R8 main on", {5'd0, pwr_main_o}, 6'd1);
    pulse_off();
    chk("R8 one-cycle drop", {5'd0, pwr_main_o}, 6'd0);
    tick(1);
    chk("R8 replay", {5'd0, pwr_main_o}, 6'd1);
    chk("R8 src replay pad1", wake_src_o, 6'b000010);
    pulse_off(); tick(3);
    chk("R8 memory drained", {5'd0, pwr_main_o}, 6'd0);
    rec_en_i = 1'b0;

    // Random phase against the reference model.
    void'($urandom(32'h1d2c3b4a));
    rst = 1'b1; tick(2); rst = 1'b0; rand_on = 1'b1; tick(1);
    for (int c = 0; c < 6000; c++) begin
      chk("R4 main", {5'd0, pwr_main_o}, {5'd0, m_main});
      chk("R5 aux", {5'd0, pwr_aux_o}, {5'd0, m_aux});
      chk("R9 src", wake_src_o, m_src);
      chk("R10 live", live_evt_o, m_live);
      if (c % 300 == 0) begin
        main_sel_i = 3'($urandom % 8);
        aux_sel_i  = 3'($urandom % 8);
        cmp_mode_i = 2'($urandom % 4);
        pull_up_i  = 1'($urandom % 2);
        rec_en_i   = 1'($urandom % 2);
      end
      for (int p = 0; p < 4; p++) if ($urandom % 14 == 0) pad_i[p] = ~pad_i[p];
      alarm_i  = ($urandom % 23 == 0);
      sw_on_i  = ($urandom % 29 == 0);
      sw_off_i = ($urandom % 17 == 0);
      tick(1);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule